// File: doc/BRIEF.md
# Chroma Saturation and Channel Override Stage

This block is the last per-pixel step of a camera colour pipe. Each cycle it can accept one pixel of three 8-bit samples. A mode input says whether the samples are luma/chroma (Y, Cb, Cr) or red/green/blue. In luma/chroma mode the two chroma samples are pulled toward or pushed away from the neutral mid-level 128. A 3-bit code picks the gain, from full grey up to over-saturation. The stage then applies two optional overrides. The first broadcasts the luma (or green) sample onto every slot to give a monochrome picture. The second forces any chosen slot to a fixed neutral value.

All control fields are static inputs. They are captured together with the pixel they apply to, so a change takes effect on a pixel boundary. The result appears exactly two clock cycles after the input. The valid flag and the line-start and frame-start markers are delayed by the same amount. The block is placed between the colour-processing logic and the output formatter.

Top module: `chroma_sat_stage`

## Requirements
- R1: An input captured on a rising edge with `in_valid` high appears at the outputs after the second rising edge. `out_valid`, `out_sol` and `out_sof` follow the same two-cycle delay. A marker is passed on only when `in_valid` was high with it.
- R2: Pixel packing is fixed. Bits [23:16] carry Y (or G), bits [15:8] carry Cb (or B) and bits [7:0] carry Cr (or R). `rgb_mode` = 0 selects luma/chroma and `rgb_mode` = 1 selects red/green/blue.
- R3: In luma/chroma mode each chroma sample C becomes clamp(128 + floor((C−128)·k/8), 0, 255). The factor k depends on `sat_code`: 000→8, 001→6, 010→4, 011→3, 100→2, 101→12, 110→0.
- R4: `sat_code` 111 behaves like 000 (unity gain). The luma sample is never changed by the saturation step.
- R5: In red/green/blue mode `sat_code` has no effect, and with no overrides the pixel passes through unchanged.
- R6: When `mono_en` is high, all three output slots carry the value of the [23:16] slot.
- R7: `kill_cb` forces slot [15:8] to 128 in luma/chroma mode and to 0 in red/green/blue mode.
- R8: `kill_luma` forces slot [23:16] to 128 in luma/chroma mode and to 0 in red/green/blue mode.
- R9: `kill_cr` forces slot [7:0] to 128 in luma/chroma mode and to 0 in red/green/blue mode.
- R10: The steps run in a fixed order: saturation, then the monochrome broadcast, then the slot overrides. An override therefore wins over the broadcast.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel present |
| in_sol | input | 1 | First pixel of a line |
| in_sof | input | 1 | First pixel of a frame |
| in_pix | input | 24 | Input pixel, slots Y/G, Cb/B, Cr/R from high to low |
| rgb_mode | input | 1 | 0 luma/chroma, 1 red/green/blue |
| sat_code | input | 3 | Chroma gain selector |
| mono_en | input | 1 | Broadcast the high slot onto all slots |
| kill_luma | input | 1 | Force slot [23:16] to neutral |
| kill_cb | input | 1 | Force slot [15:8] to neutral |
| kill_cr | input | 1 | Force slot [7:0] to neutral |
| out_valid | output | 1 | Output pixel present |
| out_sol | output | 1 | Line-start marker, aligned |
| out_sof | output | 1 | Frame-start marker, aligned |
| out_pix | output | 24 | Processed pixel |

## Verification
Every result is due two rising edges after its input is sampled. This covers the pixel value, the valid flag and both markers. The controls travel with the pixel, so a control change affects only pixels sampled after it. The bench drives inputs on the falling edge. Its behavioural model pushes a prediction through a two-entry delay line on each rising edge. The bench then compares every output on the following falling edge, once both pipeline registers have settled. The hand-worked cases for clamping and operation order are read exactly two falling edges after their pixel is driven.

// File: rtl/csat_pkg.sv
package csat_pkg;

    typedef enum logic [2:0] {
        SAT_FULL = 3'b000,
        SAT_75   = 3'b001,
        SAT_50   = 3'b010,
        SAT_37   = 3'b011,
        SAT_25   = 3'b100,
        SAT_150  = 3'b101,
        SAT_GREY = 3'b110,
        SAT_RSVD = 3'b111
    } sat_code_e;

    typedef struct packed {
        logic      rgb;
        sat_code_e sat;
        logic      mono;
        logic      kill_s0;
        logic      kill_s1;
        logic      kill_s2;
    } ctrl_t;

    typedef struct packed {
        logic vld;
        logic sol;
        logic sof;
    } side_t;

    localparam int unsigned NSLOT = 3;

endpackage

// File: rtl/csat_chroma_scale.sv
module csat_chroma_scale
    import csat_pkg::*;
#(
    parameter int unsigned CH_W = 8
) (
    input  logic [CH_W-1:0] c_in,
    input  sat_code_e       code,
    output logic [CH_W-1:0] c_out
);
    localparam int unsigned XW = CH_W + 5;
    localparam logic signed [XW-1:0] MID_S = {{(XW-CH_W){1'b0}}, 1'b1, {(CH_W-1){1'b0}}};
    localparam logic signed [XW-1:0] TOP_S = {{(XW-CH_W){1'b0}}, {CH_W{1'b1}}};

    logic signed [XW-1:0] dx;
    logic signed [XW-1:0] prod;
    logic signed [XW-1:0] sum;

    always_comb begin
        dx = $signed({{(XW-CH_W){1'b0}}, c_in}) - MID_S;
        unique case (code)
            SAT_FULL, SAT_RSVD: prod = dx <<< 3;
            SAT_75:             prod = (dx <<< 2) + (dx <<< 1);
            SAT_50:             prod = dx <<< 2;
            SAT_37:             prod = (dx <<< 1) + dx;
            SAT_25:             prod = dx <<< 1;
            SAT_150:            prod = (dx <<< 3) + (dx <<< 2);
            SAT_GREY:           prod = '0;
            default:            prod = dx <<< 3;
        endcase
        sum = (prod >>> 3) + MID_S;
        if (sum < 0)
            c_out = '0;
        else if (sum > TOP_S)
            c_out = {CH_W{1'b1}};
        else
            c_out = sum[CH_W-1:0];
    end
endmodule

// File: rtl/csat_sat_stage.sv
module csat_sat_stage
    import csat_pkg::*;
#(
    parameter int unsigned CH_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  side_t                 side_in,
    input  ctrl_t                 ctrl_in,
    input  logic [NSLOT*CH_W-1:0] pix_in,
    output side_t                 side_q,
    output ctrl_t                 ctrl_q,
    output logic [NSLOT*CH_W-1:0] pix_q
);
    localparam int unsigned PIX_W = NSLOT * CH_W;

    logic [PIX_W-1:0] pix_next;

    assign pix_next[PIX_W-1 -: CH_W] = pix_in[PIX_W-1 -: CH_W];

    generate
        for (genvar g = 1; g < NSLOT; g++) begin : g_chroma
            logic [CH_W-1:0] scaled;
            csat_chroma_scale #(.CH_W(CH_W)) u_scale (
                .c_in  (pix_in[(NSLOT-1-g)*CH_W +: CH_W]),
                .code  (ctrl_in.sat),
                .c_out (scaled)
            );
            assign pix_next[(NSLOT-1-g)*CH_W +: CH_W] =
                ctrl_in.rgb ? pix_in[(NSLOT-1-g)*CH_W +: CH_W] : scaled;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            side_q <= '0;
            ctrl_q <= '0;
            pix_q  <= '0;
        end else begin
            side_q.vld <= side_in.vld;
            side_q.sol <= side_in.vld & side_in.sol;
            side_q.sof <= side_in.vld & side_in.sof;
            ctrl_q     <= ctrl_in;
            pix_q      <= pix_next;
        end
    end
endmodule

// File: rtl/csat_override_stage.sv
module csat_override_stage
    import csat_pkg::*;
#(
    parameter int unsigned CH_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  side_t                 side_in,
    input  ctrl_t                 ctrl_in,
    input  logic [NSLOT*CH_W-1:0] pix_in,
    output side_t                 side_q,
    output logic [NSLOT*CH_W-1:0] pix_q
);
    localparam int unsigned PIX_W = NSLOT * CH_W;
    localparam logic [CH_W-1:0] MID = {1'b1, {(CH_W-1){1'b0}}};

    logic [NSLOT-1:0] kill_vec;
    logic [CH_W-1:0]  neutral;
    logic [PIX_W-1:0] pix_next;

    assign kill_vec = {ctrl_in.kill_s0, ctrl_in.kill_s1, ctrl_in.kill_s2};
    assign neutral  = ctrl_in.rgb ? '0 : MID;

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_slot
            logic [CH_W-1:0] bcast;
            assign bcast = ctrl_in.mono ? pix_in[PIX_W-1 -: CH_W]
                                        : pix_in[(NSLOT-1-g)*CH_W +: CH_W];
            assign pix_next[(NSLOT-1-g)*CH_W +: CH_W] =
                kill_vec[NSLOT-1-g] ? neutral : bcast;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            side_q <= '0;
            pix_q  <= '0;
        end else begin
            side_q <= side_in;
            pix_q  <= pix_next;
        end
    end
endmodule

// File: rtl/chroma_sat_stage.sv
module chroma_sat_stage
    import csat_pkg::*;
#(
    parameter int unsigned CH_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sol,
    input  logic                  in_sof,
    input  logic [3*CH_W-1:0]     in_pix,
    input  logic                  rgb_mode,
    input  logic [2:0]            sat_code,
    input  logic                  mono_en,
    input  logic                  kill_luma,
    input  logic                  kill_cb,
    input  logic                  kill_cr,
    output logic                  out_valid,
    output logic                  out_sol,
    output logic                  out_sof,
    output logic [3*CH_W-1:0]     out_pix
);
    localparam int unsigned PIX_W = NSLOT * CH_W;

    side_t            side_in;
    ctrl_t            ctrl_in;
    side_t            side_mid;
    ctrl_t            ctrl_mid;
    logic [PIX_W-1:0] pix_mid;
    side_t            side_out;

    always_comb begin
        side_in.vld     = in_valid;
        side_in.sol     = in_sol;
        side_in.sof     = in_sof;
        ctrl_in.rgb     = rgb_mode;
        ctrl_in.sat     = sat_code_e'(sat_code);
        ctrl_in.mono    = mono_en;
        ctrl_in.kill_s0 = kill_luma;
        ctrl_in.kill_s1 = kill_cb;
        ctrl_in.kill_s2 = kill_cr;
    end

    csat_sat_stage #(.CH_W(CH_W)) u_sat (
        .clk     (clk),
        .rst_n   (rst_n),
        .side_in (side_in),
        .ctrl_in (ctrl_in),
        .pix_in  (in_pix),
        .side_q  (side_mid),
        .ctrl_q  (ctrl_mid),
        .pix_q   (pix_mid)
    );

    csat_override_stage #(.CH_W(CH_W)) u_ovr (
        .clk     (clk),
        .rst_n   (rst_n),
        .side_in (side_mid),
        .ctrl_in (ctrl_mid),
        .pix_in  (pix_mid),
        .side_q  (side_out),
        .pix_q   (out_pix)
    );

    assign out_valid = side_out.vld;
    assign out_sol   = side_out.sol;
    assign out_sof   = side_out.sof;
endmodule

// File: rtl/csat_checks.sv
module csat_checks #(
    parameter int unsigned CH_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3*CH_W-1:0] in_pix,
    input logic              rgb_mode,
    input logic              mono_en,
    input logic              kill_luma,
    input logic              kill_cb,
    input logic              kill_cr,
    input logic              out_valid,
    input logic              out_sol,
    input logic              out_sof,
    input logic [3*CH_W-1:0] out_pix
);
    localparam logic [CH_W-1:0] MID = {1'b1, {(CH_W-1){1'b0}}};

    logic [1:0] since_rst;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end
    assign warm = (since_rst >= 2'd2);

    a_r1_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 2)));

    a_r1_sol_in_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sol |-> out_valid);

    a_r1_sof_in_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    a_r11_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && !out_sol && !out_sof && out_pix == '0));

    a_r5_rgb_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(rgb_mode, 2) && !$past(mono_en, 2) && !$past(kill_luma, 2)
         && !$past(kill_cb, 2) && !$past(kill_cr, 2))
        |-> (out_pix == $past(in_pix, 2)));

    a_r6_mono_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(mono_en, 2) && !$past(kill_luma, 2) && !$past(kill_cb, 2)
         && !$past(kill_cr, 2))
        |-> (out_pix[2*CH_W-1:CH_W] == out_pix[3*CH_W-1:2*CH_W]
             && out_pix[CH_W-1:0] == out_pix[3*CH_W-1:2*CH_W]));

    a_r7_cb_kill: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(kill_cb, 2))
        |-> (out_pix[2*CH_W-1:CH_W] == ($past(rgb_mode, 2) ? '0 : MID)));

    a_r8_luma_kill: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(kill_luma, 2))
        |-> (out_pix[3*CH_W-1:2*CH_W] == ($past(rgb_mode, 2) ? '0 : MID)));

    a_r9_cr_kill: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(kill_cr, 2))
        |-> (out_pix[CH_W-1:0] == ($past(rgb_mode, 2) ? '0 : MID)));
endmodule

bind chroma_sat_stage csat_checks #(.CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_pix    (in_pix),
    .rgb_mode  (rgb_mode),
    .mono_en   (mono_en),
    .kill_luma (kill_luma),
    .kill_cb   (kill_cb),
    .kill_cr   (kill_cr),
    .out_valid (out_valid),
    .out_sol   (out_sol),
    .out_sof   (out_sof),
    .out_pix   (out_pix)
);

// File: tb/sim_chroma_sat_stage.sv
`timescale 1ns/1ps
module sim_chroma_sat_stage;
    localparam int CH_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
    logic [23:0] in_pix = '0;
    logic        rgb_mode = 1'b0, mono_en = 1'b0;
    logic [2:0]  sat_code = 3'd0;
    logic        kill_luma = 1'b0, kill_cb = 1'b0, kill_cr = 1'b0;
    logic        out_valid, out_sol, out_sof;
    logic [23:0] out_pix;

    int    total = 0;
    int    bad = 0;
    bit    finished = 1'b0;
    string cur_req = "R2";

    always #2.5 clk = ~clk;

    chroma_sat_stage #(.CH_W(CH_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof),
        .in_pix(in_pix), .rgb_mode(rgb_mode), .sat_code(sat_code), .mono_en(mono_en),
        .kill_luma(kill_luma), .kill_cb(kill_cb), .kill_cr(kill_cr),
        .out_valid(out_valid), .out_sol(out_sol), .out_sof(out_sof), .out_pix(out_pix)
    );

    // Reference model: behavioural arithmetic from R3..R10
    function automatic int scale_c(int c, int code);
        int k, d, p, q, r;
        case (code)
            1: k = 6;  2: k = 4;  3: k = 3;  4: k = 2;
            5: k = 12; 6: k = 0;  default: k = 8;
        endcase
        d = c - 128;
        p = d * k;
        q = (p >= 0) ? p / 8 : -((-p + 7) / 8);
        r = 128 + q;
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    function automatic logic [23:0] model(logic [23:0] px, logic rgb, logic [2:0] sc,
                                          logic mono, logic kl, logic kb, logic kr);
        int s[3];
        int neu;
        s[0] = px[23:16]; s[1] = px[15:8]; s[2] = px[7:0];
        if (!rgb) begin
            s[1] = scale_c(s[1], sc);
            s[2] = scale_c(s[2], sc);
        end
        if (mono) begin
            s[1] = s[0];
            s[2] = s[0];
        end
        neu = rgb ? 0 : 128;
        if (kl) s[0] = neu;
        if (kb) s[1] = neu;
        if (kr) s[2] = neu;
        return {s[0][7:0], s[1][7:0], s[2][7:0]};
    endfunction

    logic [26:0] exp1, exp2;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp1 <= '0;
            exp2 <= '0;
        end else begin
            exp2 <= exp1;
            exp1 <= {in_valid, in_valid & in_sol, in_valid & in_sof,
                     model(in_pix, rgb_mode, sat_code, mono_en, kill_luma, kill_cb, kill_cr)};
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(logic v, logic sol, logic sof, logic [23:0] px);
        in_valid = v; in_sol = sol; in_sof = sof; in_pix = px;
        @(negedge clk);
        chk("R1 sideband", {29'd0, out_valid, out_sol, out_sof}, {29'd0, exp2[26:24]});
        chk(cur_req, {8'd0, out_pix}, {8'd0, exp2[23:0]});
    endtask

    task automatic set_ctrl(logic rgb, logic [2:0] sc, logic mono, logic kl, logic kb, logic kr);
        rgb_mode = rgb; sat_code = sc; mono_en = mono;
        kill_luma = kl; kill_cb = kb; kill_cr = kr;
    endtask

    task automatic burst(int n);
        for (int i = 0; i < n; i++)
            step(1'b1, (i % 8) == 0, i == 0, 24'($urandom));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R11: outputs idle during reset even with active inputs
        in_valid = 1'b1; in_sol = 1'b1; in_sof = 1'b1; in_pix = 24'hFFFFFF;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R11 reset", {5'd0, out_valid, out_sol, out_sof, out_pix}, 32'd0);
        end
        in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0;
        rst_n = 1'b1;

        // R2/R4: unity gain in luma/chroma mode
        cur_req = "R2"; set_ctrl(0, 3'd0, 0, 0, 0, 0); burst(20);
        // R4: reserved code acts as unity
        cur_req = "R4"; set_ctrl(0, 3'd7, 0, 0, 0, 0); burst(20);

        // R3: every gain code with extremes and random samples
        cur_req = "R3";
        for (int c = 1; c <= 6; c++) begin
            set_ctrl(0, 3'(c), 0, 0, 0, 0);
            step(1, 1, 1, 24'h10_00_FF);
            step(1, 0, 0, 24'h80_80_7F);
            step(1, 0, 0, 24'hEE_01_81);
            burst(10);
        end

        // R3: hand-worked 150% case with clamping, read two edges later
        set_ctrl(0, 3'd5, 0, 0, 0, 0);
        step(1, 0, 0, 24'h64_C8_0A);
        step(0, 0, 0, 24'h0);
        chk("R3 clamp", {8'd0, out_pix}, 32'h0064_EC00);

        // R1: gaps in valid and markers on idle cycles must not pass
        cur_req = "R1";
        for (int i = 0; i < 30; i++)
            step(i % 3 != 0, 1'b1, i % 5 == 0, 24'($urandom));

        // R5: sat code ignored in RGB mode
        cur_req = "R5";
        for (int c = 0; c < 8; c++) begin
            set_ctrl(1, 3'(c), 0, 0, 0, 0);
            burst(6);
        end

        // R6: monochrome in both modes
        cur_req = "R6"; set_ctrl(0, 3'd1, 1, 0, 0, 0); burst(12);
        set_ctrl(1, 3'd0, 1, 0, 0, 0); burst(12);

        // R7, R8, R9: overrides in each mode
        for (int m = 0; m < 2; m++) begin
            cur_req = "R7"; set_ctrl(m[0], 3'd2, 0, 0, 1, 0); burst(8);
            cur_req = "R8"; set_ctrl(m[0], 3'd2, 0, 1, 0, 0); burst(8);
            cur_req = "R9"; set_ctrl(m[0], 3'd2, 0, 0, 0, 1); burst(8);
        end

        // R10: override wins over broadcast
        cur_req = "R10";
        set_ctrl(0, 3'd5, 1, 0, 1, 0);
        step(1, 0, 0, 24'h32_00_FF);
        step(0, 0, 0, 24'h0);
        chk("R10 order", {8'd0, out_pix}, 32'h0032_8032);
        set_ctrl(1, 3'd3, 1, 0, 0, 1); burst(10);
        for (int i = 0; i < 40; i++) begin
            set_ctrl(1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
                     1'($urandom), 1'($urandom));
            step(1'($urandom), 1'($urandom), 1'($urandom), 24'($urandom));
        end
        set_ctrl(0, 3'd0, 0, 0, 0, 0);
        step(0, 0, 0, 24'h0);
        step(0, 0, 0, 24'h0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule